// File: doc/BRIEF.md
# Compliance Entry and Setting Sequencer

This block is a narrow part of link-training control. While the link sits in active polling it decides whether to move into compliance mode. It can move on a software force bit, or it can move when the polling timer expires and one of two conditions holds: the receiver has collected a run of eight matching training sets, or some lane never left electrical idle. Each visit to compliance uses the next entry of a numbered list of compliance settings. The setting counter survives returns to polling, so successive visits walk the list.

A per-setting enable mask lets a bench or test program skip settings. On each entry the counter jumps ahead to the next enabled setting, so any single setting can be reached in one visit. The current setting selects a data-rate code and a per-lane pattern code from a small computed lookup. The entries in that lookup are placeholders that stand in for the full preset table. The decoded training-set input is a one-cycle strobe per received set and has no ready signal, because a receiver cannot stall the line. All other pins are plain level controls and status.

Top module: `cmp_compliance_seq`

## Requirements
- R1: While polling, a high `force_compl` starts a compliance entry without waiting for the timer.
- R2: When the polling timer expires and the last eight training sets seen in this polling visit all had compliance-request set and loopback-request clear, an entry starts. Any non-matching set resets the run, and a run shorter than eight does not cause entry.
- R3: When the polling timer expires and any bit of `eidle_exit` is 0, an entry starts.
- R4: When the timer expires and neither R2 nor R3 holds, the block stays in polling and the timer starts over.
- R5: Rate codes are 0=2.5, 1=5, 2=8, 3=16, 4=32, 5=64 and 6=128 GT/s. An entry spends one cycle at code 0 with `compl_active` low. After that, `compl_active` is high and `rate_code` equals 1+((setting-1) mod TOP), where TOP is 4, 5 or 6 for GEN 0, 1 or 2. Outside compliance, `rate_code` is 0.
- R6: On entry the setting becomes the lowest enabled setting above the current one. If there is none, it wraps to the lowest enabled setting. Mask bit i enables setting i+1. The setting changes at no other time.
- R7: A high `exit_req` during compliance returns the block to polling on the next cycle, and the setting number is kept.
- R8: If an entry is attempted while the mask is all zero, `no_setting_err` goes to 1 and the block stays in polling. A later successful entry clears the flag.
- R9: Setting 84 drives pattern code 3 (low-swing toggle) on every lane. Setting 159 drives code 4 (short high-swing toggle) on every lane.
- R10: Pattern codes are 0 = compliance, 1 = jitter and 2 = high-swing toggle, with lane L in bits [3L+2:3L]. For other settings s, the code depends on s mod 4. If it is 0, every lane gets 0. If it is 1, every lane gets 1. If it is 2, lanes with L mod (LANES/2) = (s/4) mod (LANES/2) get 1 and all other lanes get 0. If it is 3, the same lanes get 2 and all other lanes get 0. Outside compliance every lane reads 0.
- R11: The highest setting is 54, 84 or 167 for GEN 0, 1 or 2, and the setting wraps from that value to the bottom of the list.
- R12: The training-set run count starts from zero on each new visit to polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_compl | input | 1 | Software force into compliance |
| ts_valid | input | 1 | One-cycle strobe per decoded training set |
| ts_compl_req | input | 1 | Compliance-request flag of that set |
| ts_loop_req | input | 1 | Loopback-request flag of that set |
| eidle_exit | input | LANES | Per-lane flag: lane has left electrical idle |
| setting_en | input | MAX_SET | Enable mask, bit i for setting i+1 |
| exit_req | input | 1 | Request to leave compliance |
| compl_active | output | 1 | In compliance with settings applied |
| setting_num | output | SET_W | Current setting number (0 before first entry) |
| rate_code | output | 3 | Data-rate code |
| lane_pattern | output | 3*LANES | Per-lane pattern code |
| no_setting_err | output | 1 | Entry attempted with every setting disabled |

## Verification
The bench attacks the training-set run in three ways: a run broken by a loopback-flagged set, a run one short of eight, and a full run carried over a compliance visit. A design that does not reset the run, or that keeps it across visits, enters compliance on a timeout when it must not. Sparse random masks, and a mask holding only the top setting, test the skip-and-wrap search. An off-by-one or a missing wrap there shows up as a wrong setting number. The two all-lane settings and the lane-pair rule are checked lane by lane, and an all-zero mask must raise the error without leaving polling.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {ST_POLL = 2'd0, ST_ENTRY = 2'd1, ST_COMPL = 2'd2} cmp_state_e;

  localparam logic [2:0] PAT_COMPL = 3'd0;
  localparam logic [2:0] PAT_JIT   = 3'd1;
  localparam logic [2:0] PAT_HSTP  = 3'd2;
  localparam logic [2:0] PAT_LSTP  = 3'd3;
  localparam logic [2:0] PAT_SHSTP = 3'd4;

  localparam int LSTP_SETTING  = 84;
  localparam int SHSTP_SETTING = 159;

  function automatic int max_setting(input int gen);
    case (gen)
      0:       return 54;
      1:       return 84;
      default: return 167;
    endcase
  endfunction

  function automatic int top_rate(input int gen);
    case (gen)
      0:       return 4;
      1:       return 5;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/cmp_ts_run.sv
module cmp_ts_run #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ts_valid,
  input  logic ts_compl_req,
  input  logic ts_loop_req,
  output logic run_full
);
  localparam int CW = $clog2(RUN_LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (ts_valid) begin
      if (ts_compl_req && !ts_loop_req) begin
        if (cnt_q != CW'(RUN_LEN)) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign run_full = (cnt_q == CW'(RUN_LEN));
endmodule

// File: rtl/cmp_poll_timer.sv
module cmp_poll_timer #(
  parameter int TIMEOUT_CYC = 1200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  logic [TW-1:0] tcnt_q;

  assign expired = (tcnt_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || expired) tcnt_q <= '0;
    else                              tcnt_q <= tcnt_q + 1'b1;
  end
endmodule

// File: rtl/cmp_setting_pick.sv
module cmp_setting_pick #(
  parameter int MAX_SET = 167,
  parameter int SET_W   = 8
) (
  input  logic [SET_W-1:0]   cur,
  input  logic [MAX_SET-1:0] en_mask,
  output logic [SET_W-1:0]   pick,
  output logic               any_en
);
  always_comb begin
    logic hit_hi, hit_lo;
    logic [SET_W-1:0] p_hi, p_lo;
    hit_hi = 1'b0;
    hit_lo = 1'b0;
    p_hi   = '0;
    p_lo   = '0;
    for (int i = 1; i <= MAX_SET; i++) begin
      if (en_mask[i-1] && !hit_lo) begin
        hit_lo = 1'b1;
        p_lo   = SET_W'(i);
      end
      if (en_mask[i-1] && !hit_hi && (SET_W'(i) > cur)) begin
        hit_hi = 1'b1;
        p_hi   = SET_W'(i);
      end
    end
    any_en = hit_lo;
    pick   = hit_hi ? p_hi : p_lo;
  end
endmodule

// File: rtl/cmp_setting_map.sv
module cmp_setting_map
  import cmp_pkg::*;
#(
  parameter int GEN   = 2,
  parameter int SET_W = 8,
  parameter int LANES = 16
) (
  input  logic               active,
  input  logic [SET_W-1:0]   setting,
  output logic [2:0]         rate,
  output logic [3*LANES-1:0] lane_pat
);
  localparam int TOP  = top_rate(GEN);
  localparam int HALF = (LANES / 2 > 0) ? LANES / 2 : 1;

  int s_i;
  int pair_sel;
  assign s_i      = int'(setting);
  assign pair_sel = (s_i / 4) % HALF;

  always_comb begin
    rate = 3'd0;
    if (active && s_i >= 1) rate = 3'(1 + ((s_i - 1) % TOP));
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic on_pair;
    assign on_pair = ((L % HALF) == pair_sel);
    always_comb begin
      lane_pat[3*L +: 3] = PAT_COMPL;
      if (active) begin
        if (s_i == LSTP_SETTING)       lane_pat[3*L +: 3] = PAT_LSTP;
        else if (s_i == SHSTP_SETTING) lane_pat[3*L +: 3] = PAT_SHSTP;
        else begin
          case (s_i % 4)
            1:       lane_pat[3*L +: 3] = PAT_JIT;
            2:       lane_pat[3*L +: 3] = on_pair ? PAT_JIT  : PAT_COMPL;
            3:       lane_pat[3*L +: 3] = on_pair ? PAT_HSTP : PAT_COMPL;
            default: lane_pat[3*L +: 3] = PAT_COMPL;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cmp_compliance_seq.sv
module cmp_compliance_seq
  import cmp_pkg::*;
#(
  parameter int GEN         = 2,
  parameter int LANES       = 16,
  parameter int TIMEOUT_CYC = 1200000,
  parameter int RUN_LEN     = 8,
  localparam int MAX_SET    = max_setting(GEN),
  localparam int SET_W      = $clog2(MAX_SET + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_compl,
  input  logic               ts_valid,
  input  logic               ts_compl_req,
  input  logic               ts_loop_req,
  input  logic [LANES-1:0]   eidle_exit,
  input  logic [MAX_SET-1:0] setting_en,
  input  logic               exit_req,
  output logic               compl_active,
  output logic [SET_W-1:0]   setting_num,
  output logic [2:0]         rate_code,
  output logic [3*LANES-1:0] lane_pattern,
  output logic               no_setting_err
);
  cmp_state_e      st_q;
  logic [SET_W-1:0] set_q;
  logic             err_q;
  logic             not_poll, run_full, tmo, any_en, try_entry;
  logic [SET_W-1:0] nxt_set;

  assign not_poll = (st_q != ST_POLL);

  cmp_ts_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(not_poll), .ts_valid(ts_valid),
    .ts_compl_req(ts_compl_req), .ts_loop_req(ts_loop_req), .run_full(run_full)
  );

  cmp_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(not_poll), .expired(tmo)
  );

  cmp_setting_pick #(.MAX_SET(MAX_SET), .SET_W(SET_W)) u_pick (
    .cur(set_q), .en_mask(setting_en), .pick(nxt_set), .any_en(any_en)
  );

  assign try_entry = force_compl || (tmo && (run_full || !(&eidle_exit)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_POLL;
      set_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (st_q)
        ST_POLL: if (try_entry) begin
          if (any_en) st_q  <= ST_ENTRY;
          else        err_q <= 1'b1;
        end
        ST_ENTRY: if (any_en) begin
          set_q <= nxt_set;
          err_q <= 1'b0;
          st_q  <= ST_COMPL;
        end else begin
          err_q <= 1'b1;
          st_q  <= ST_POLL;
        end
        ST_COMPL: if (exit_req) st_q <= ST_POLL;
        default:  st_q <= ST_POLL;
      endcase
    end
  end

  assign compl_active   = (st_q == ST_COMPL);
  assign setting_num    = set_q;
  assign no_setting_err = err_q;

  cmp_setting_map #(.GEN(GEN), .SET_W(SET_W), .LANES(LANES)) u_map (
    .active(compl_active), .setting(set_q), .rate(rate_code), .lane_pat(lane_pattern)
  );
endmodule

// File: rtl/cmp_compliance_seq_chk.sv
module cmp_compliance_seq_chk #(
  parameter int MAX_SET = 167,
  parameter int SET_W   = 8,
  parameter int LANES   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exit_req,
  input logic [MAX_SET-1:0] setting_en,
  input logic               compl_active,
  input logic [SET_W-1:0]   setting_num,
  input logic [2:0]         rate_code,
  input logic [3*LANES-1:0] lane_pattern,
  input logic               no_setting_err
);
  // R7
  exit_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compl_active && exit_req) |=> !compl_active);
  // R5
  compl_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compl_active |-> (rate_code != 3'd0));
  // R6
  setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(compl_active) |-> $stable(setting_num));
  // R6
  setting_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(compl_active) && $stable(setting_en)) |-> setting_en[setting_num - 1'b1]);
  // R11
  setting_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compl_active |-> (setting_num >= SET_W'(1) && setting_num <= SET_W'(MAX_SET)));
  // R8
  err_in_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_setting_err |-> !compl_active);
  // R9
  lstp_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compl_active && setting_num == SET_W'(84)) |-> (lane_pattern == {LANES{3'd3}}));
endmodule

bind cmp_compliance_seq cmp_compliance_seq_chk #(.MAX_SET(MAX_SET), .SET_W(SET_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .setting_en(setting_en),
  .compl_active(compl_active), .setting_num(setting_num), .rate_code(rate_code),
  .lane_pattern(lane_pattern), .no_setting_err(no_setting_err)
);

// File: tb/tb_cmp_compliance_seq.sv
module tb_cmp_compliance_seq;
  localparam int GEN   = 2;
  localparam int LANES = 16;
  localparam int TMO   = 40;
  localparam int MAXS  = cmp_pkg::max_setting(GEN);
  localparam int SW    = $clog2(MAXS + 1);
  localparam int TOPR  = cmp_pkg::top_rate(GEN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic force_compl = 0, ts_valid = 0, ts_compl_req = 0, ts_loop_req = 0, exit_req = 0;
  logic [LANES-1:0] eidle_exit = '1;
  logic [MAXS-1:0]  setting_en = '1;
  logic compl_active, no_setting_err;
  logic [SW-1:0] setting_num;
  logic [2:0] rate_code;
  logic [3*LANES-1:0] lane_pattern;

  int checks = 0, errors = 0;
  int model_set = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_compliance_seq #(.GEN(GEN), .LANES(LANES), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .force_compl(force_compl), .ts_valid(ts_valid),
    .ts_compl_req(ts_compl_req), .ts_loop_req(ts_loop_req), .eidle_exit(eidle_exit),
    .setting_en(setting_en), .exit_req(exit_req), .compl_active(compl_active),
    .setting_num(setting_num), .rate_code(rate_code), .lane_pattern(lane_pattern),
    .no_setting_err(no_setting_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_pick(input int cur, input logic [MAXS-1:0] m);
    for (int i = cur + 1; i <= MAXS; i++) if (m[i-1]) return i;
    for (int i = 1; i <= MAXS; i++) if (m[i-1]) return i;
    return -1;
  endfunction

  function automatic int exp_rate(input int s);
    return 1 + ((s - 1) % TOPR);
  endfunction

  function automatic logic [3*LANES-1:0] exp_pat(input int s);
    logic [3*LANES-1:0] v;
    int half = LANES / 2;
    for (int L = 0; L < LANES; L++) begin
      logic [2:0] c;
      bit pr = ((L % half) == ((s / 4) % half));
      if (s == 84) c = 3;
      else if (s == 159) c = 4;
      else case (s % 4)
        1: c = 1;
        2: c = pr ? 3'd1 : 3'd0;
        3: c = pr ? 3'd2 : 3'd0;
        default: c = 0;
      endcase
      v[3*L +: 3] = c;
    end
    return v;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Force entry; check one-cycle 2.5 stage then the setting outputs.
  task automatic force_entry(input string tag);
    int e;
    force_compl = 1;
    cyc(1);
    force_compl = 0;
    chk(!compl_active && rate_code == 0, "R5", rate_code, 0);
    cyc(1);
    e = exp_pick(model_set, setting_en);
    chk(compl_active == 1, "R1", compl_active, 1);
    chk(int'(setting_num) == e, tag, setting_num, e);
    chk(int'(rate_code) == exp_rate(e), "R5", rate_code, exp_rate(e));
    chk(lane_pattern == exp_pat(e), "R10", lane_pattern, exp_pat(e));
    model_set = e;
  endtask

  task automatic leave();
    exit_req = 1;
    cyc(1);
    exit_req = 0;
    chk(!compl_active && int'(setting_num) == model_set, "R7", setting_num, model_set);
    chk(rate_code == 0 && lane_pattern == '0, "R10", lane_pattern, 0);
  endtask

  task automatic send_ts(input bit cr, input bit lb);
    ts_valid = 1; ts_compl_req = cr; ts_loop_req = lb;
    cyc(1);
    ts_valid = 0; ts_compl_req = 0; ts_loop_req = 0;
  endtask

  // Watch for entry over n cycles, return cycle of rise (-1 if none).
  task automatic watch(input int n, output int at);
    at = -1;
    for (int k = 1; k <= n; k++) begin
      cyc(1);
      if (compl_active && at < 0) at = k;
    end
  endtask

  initial begin
    int at;
    logic [MAXS-1:0] m;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(!compl_active && setting_num == 0 && rate_code == 0 && !no_setting_err, "R5", setting_num, 0);

    // R4: no condition, timer expires several times, stays polling
    watch(3 * TMO, at);
    chk(at < 0, "R4", at, -1);

    // R1 / R6: first forced entry gives setting 1
    force_entry("R6");
    leave();
    force_entry("R6");
    leave();

    // R3: one lane still idle, entry on timeout
    eidle_exit[5] = 0;
    watch(TMO + 4, at);
    eidle_exit = '1;
    chk(at >= TMO - 2 && at <= TMO + 3, "R3", at, TMO);
    model_set = exp_pick(model_set, setting_en);
    chk(int'(setting_num) == model_set, "R3", setting_num, model_set);
    leave();

    // R2: broken run (5 good, loopback one, 7 good) -> no entry
    for (int i = 0; i < 5; i++) send_ts(1, 0);
    send_ts(1, 1);
    for (int i = 0; i < 7; i++) send_ts(1, 0);
    watch(2 * TMO, at);
    chk(at < 0, "R2", at, -1);
    send_ts(0, 0);
    for (int i = 0; i < 8; i++) send_ts(1, 0);
    watch(TMO + 4, at);
    chk(at > 0, "R2", at, 1);
    model_set = exp_pick(model_set, setting_en);
    leave();

    // R12: full run, forced entry, return -> run count starts over
    for (int i = 0; i < 8; i++) send_ts(1, 0);
    force_entry("R6");
    leave();
    watch(2 * TMO, at);
    chk(at < 0, "R12", at, -1);

    // R9: low-swing and short high-swing settings
    setting_en = '0; setting_en[83] = 1;
    force_entry("R9");
    chk(lane_pattern == {LANES{3'd3}}, "R9", lane_pattern, {LANES{3'd3}});
    leave();
    setting_en = '0; setting_en[158] = 1;
    force_entry("R9");
    chk(lane_pattern == {LANES{3'd4}}, "R9", lane_pattern, {LANES{3'd4}});
    leave();

    // R11: top setting then wrap
    setting_en = '0; setting_en[MAXS-1] = 1;
    force_entry("R11");
    chk(int'(setting_num) == MAXS, "R11", setting_num, MAXS);
    leave();
    setting_en = '1;
    force_entry("R11");
    chk(setting_num == 1, "R11", setting_num, 1);
    leave();

    // R8: all disabled
    setting_en = '0;
    force_compl = 1;
    cyc(3);
    force_compl = 0;
    cyc(1);
    chk(no_setting_err && !compl_active && int'(setting_num) == model_set, "R8", no_setting_err, 1);
    setting_en[9] = 1;
    force_entry("R8");
    chk(!no_setting_err, "R8", no_setting_err, 0);
    leave();

    // Random masks
    void'($urandom(32'd4242));
    for (int it = 0; it < 60; it++) begin
      for (int b = 0; b < MAXS; b++) m[b] = (($urandom % 16) == 0);
      m[$urandom % MAXS] = 1;
      setting_en = m;
      force_entry("R6");
      leave();
      cyc($urandom % 3);
    end

    done = 1;
  end

  initial begin
    for (int w = 0; w < 100000; w++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule